// File: doc/BRIEF.md
# Cache-Line Read Return Sequencer

This block is the responder on the memory-controller side of a cache-line read path. A cache bank presents a read request carrying the upper line address, one extra address bit, a request tag and a flag that marks the read as a dummy. The block acknowledges the request with a one-cycle pulse and parks it in an in-order queue. Later it returns the 512-bit line as four 128-bit quadwords on a data bus that it shares with a sibling bank. Each quadword carries a 28-bit check field: one 7-bit code for every 32-bit half of its two 64-bit words.

The return begins at the quadword the requester asked for and wraps modulo four. The four quadwords go out as two groups of two. For each group the block first sends two strobe cycles that carry the quadword number and the request tag. One quiet cycle follows, then two data beats. A programmable gap separates the two groups. A small line store holds the data. The store takes full-line writes, and a read that targets a 512-byte block under write waits until the write finishes. Between transfers the data bus carries a fixed filler pattern.

Top module: `line_return_seq`

## Requirements
- R1: With room available, `rd_ack_o` goes high for exactly one cycle, ACK_DELAY+1 rising edges after the first edge at which `rd_req_i` is sampled high. The requester holds `rd_req_i` and its fields until it sees the acknowledge.
- R2: At most SLOTS reads are acknowledged and not yet returned. A further request gets no acknowledge until a return completes, and it is acknowledged shortly after that.
- R3: At most one dummy read is outstanding. A second dummy request gets no acknowledge while the first is pending, but a normal request is still accepted.
- R4: The line address is rebuilt as {rd_addr_hi_i, INSTANCE[0]} (address bits 39:6). The store index is its low LINE_IDX_W bits. The starting quadword is {rd_addr5_i, 0}, so it is always 0 or 2.
- R5: Each group drives `rsp_vld_o` high for two cycles, carrying `rsp_qid_o` and the request tag on `rsp_id_o`. One cycle with `rsp_vld_o` low follows, then two data beats on consecutive cycles.
- R6: The first group carries quadwords s and s+1, and the second carries s+2 and s+3, all modulo 4. Between the last beat of the first group and the first strobe of the second, `rsp_vld_o` stays low for GAP_CYC cycles.
- R7: A beat for quadword q is {word[2q], word[2q+1]}, where word[i] is line bits 64i+63:64i. The lower-indexed word sits in bits 127:64.
- R8: `rsp_ecc_o` is {c(w0[63:32]), c(w0[31:0]), c(w1[63:32]), c(w1[31:0])}, where w0 and w1 are the beat's upper and lower words. c(d) = {p,e5..e0}. Each bit is the XOR of d under a mask: p 2DA65CB7, e5 FC000000, e4 03FFF800, e3 03FC07F0, e2 E3C3C78E, e1 9B33366D, e0 56AAAD5B (hex).
- R9: While waiting for the bus, `bus_req_o` is high. A transfer starts only when `peer_own_i` is low and `peer_req_i` is either low or yielded to (an odd INSTANCE yields). `bus_own_o` stays high from the first strobe through the last beat.
- R10: A dummy read returns an all-zero line with all-zero check codes.
- R11: A read whose block (address bits 39:9) equals `wr_line_addr_i[33:3]` while `wr_busy_i` is high does not start. Once the write is done, the read returns the newly written line.
- R12: After reset, and in every cycle that is not a data beat, `rsp_data_o` carries DEADBEEF repeated four times and `rsp_ecc_o` is zero. After reset, `rd_ack_o`, `rsp_vld_o`, `bus_req_o` and `bus_own_o` are low.
- R13: Returns leave in the order the requests were acknowledged, each with its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_i | input | 1 | Read request, held until acknowledged |
| rd_addr_hi_i | input | 33 | Line address bits 39:7 |
| rd_addr5_i | input | 1 | Address bit 5 (picks the starting quadword) |
| rd_id_i | input | ID_W | Request tag |
| rd_dummy_i | input | 1 | Dummy read flag |
| rd_ack_o | output | 1 | One-cycle acknowledge |
| wr_en_i | input | 1 | Line write strobe into the store |
| wr_busy_i | input | 1 | A write to wr_line_addr_i is in progress |
| wr_line_addr_i | input | 34 | Write line address bits 39:6 |
| wr_line_i | input | 512 | Write line data |
| peer_own_i | input | 1 | Sibling bank holds the shared bus |
| peer_req_i | input | 1 | Sibling bank is waiting for the bus |
| bus_req_o | output | 1 | This bank is waiting for the bus |
| bus_own_o | output | 1 | This bank holds the bus |
| rsp_vld_o | output | 1 | Quadword strobe |
| rsp_qid_o | output | 2 | Quadword number during the strobe |
| rsp_id_o | output | ID_W | Request tag during the strobe |
| rsp_data_o | output | 128 | Data beat or filler |
| rsp_ecc_o | output | 28 | Check codes of the beat |

## Verification
The hardest states to reach from the ports are the full queue and the pending second dummy: the outstanding counts must climb while nothing drains. The bench gets there by holding `peer_own_i` high, which freezes the sequencer in arbitration while requests keep arriving. It then confirms the missing acknowledge, releases the bus and watches the held request go through once the first return completes. The write-hazard stall is reached the same way: `wr_busy_i` is held on the target block, the store is rewritten under it, and the bench checks that the return carries the new line.

// File: rtl/lrs_pkg.sv
`timescale 1ns/1ps
package lrs_pkg;

    localparam int HI_W    = 33;   // line address bits 39:7
    localparam int LA_W    = 34;   // line address bits 39:6
    localparam int LINE_W  = 512;
    localparam int BEAT_W  = 128;
    localparam int ECC_W   = 28;
    localparam logic [BEAT_W-1:0] FILLER = {4{32'hDEAD_BEEF}};

    typedef enum logic [3:0] {
        S_IDLE, S_WAIT, S_ARB, S_V0, S_V1, S_GAP, S_D0, S_D1, S_IGAP, S_DONE
    } seq_st_e;

    // 7-bit check code of one 32-bit half: {parity, e5..e0}
    function automatic logic [6:0] half_code(input logic [31:0] d);
        half_code = {^(d & 32'h2DA6_5CB7), ^(d & 32'hFC00_0000),
                     ^(d & 32'h03FF_F800), ^(d & 32'h03FC_07F0),
                     ^(d & 32'hE3C3_C78E), ^(d & 32'h9B33_366D),
                     ^(d & 32'h56AA_AD5B)};
    endfunction

    function automatic logic [ECC_W-1:0] beat_code(input logic [63:0] hi_w,
                                                   input logic [63:0] lo_w);
        beat_code = {half_code(hi_w[63:32]), half_code(hi_w[31:0]),
                     half_code(lo_w[63:32]), half_code(lo_w[31:0])};
    endfunction

endpackage

// File: rtl/lrs_ack_ctrl.sv
`timescale 1ns/1ps
module lrs_ack_ctrl #(
    parameter int SLOTS     = 8,
    parameter int ACK_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic dummy_i,
    input  logic done_i,
    input  logic done_dummy_i,
    output logic push_o,
    output logic ack_o
);
    localparam int AW = $clog2(ACK_DELAY + 1) + 1;
    localparam int CW = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          ack;
        logic [CW-1:0] n_out;
        logic          dum;
    } ack_st_t;

    ack_st_t d, q;
    logic room;

    always_comb begin
        d      = q;
        d.ack  = 1'b0;
        push_o = 1'b0;
        room   = (q.n_out < CW'(SLOTS)) && !(dummy_i && q.dum);
        if (req_i && !q.ack) begin
            if (q.cnt != AW'(ACK_DELAY)) begin
                d.cnt = q.cnt + 1'b1;
            end else if (room) begin
                d.ack  = 1'b1;
                push_o = 1'b1;
                d.cnt  = '0;
            end
        end else begin
            d.cnt = '0;
        end
        d.n_out = q.n_out + CW'(push_o) - CW'(done_i);
        if (done_i && done_dummy_i) d.dum = 1'b0;
        if (push_o && dummy_i)      d.dum = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_o = q.ack;

    // R1
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack |=> !q.ack);

endmodule

// File: rtl/lrs_req_fifo.sv
`timescale 1ns/1ps
module lrs_req_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic         vld_o,
    output logic [W-1:0] dout_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t d, q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push_i) begin
            d.mem[q.wp] = din_i;
            d.wp        = nxt(q.wp);
        end
        if (pop_i) d.rp = nxt(q.rp);
        d.cnt = q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vld_o  = (q.cnt != '0);
    assign dout_o = q.mem[q.rp];

    // R2
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q.cnt < CW'(DEPTH)));

endmodule

// File: rtl/lrs_line_store.sv
`timescale 1ns/1ps
module lrs_line_store #(
    parameter int IDX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [lrs_pkg::LINE_W-1:0] wr_line_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic [lrs_pkg::LINE_W-1:0] rd_line_o
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0][lrs_pkg::LINE_W-1:0] mem_d, mem_q;

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) mem_d[g] = wr_line_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_line_o = mem_q[rd_idx_i];

endmodule

// File: rtl/lrs_beat_seq.sv
`timescale 1ns/1ps
module lrs_beat_seq
    import lrs_pkg::*;
#(
    parameter int INSTANCE   = 1,
    parameter int ID_W       = 3,
    parameter int RESP_DELAY = 1,
    parameter int GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_vld_i,
    input  logic [HI_W-1:0]   head_hi_i,
    input  logic              head_a5_i,
    input  logic [ID_W-1:0]   head_id_i,
    input  logic              head_dummy_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              wr_busy_i,
    input  logic [LA_W-1:0]   wr_line_addr_i,
    input  logic              peer_own_i,
    input  logic              peer_req_i,
    output logic              pop_o,
    output logic              pop_dummy_o,
    output logic              bus_req_o,
    output logic              bus_own_o,
    output logic              vld_o,
    output logic [1:0]        qid_o,
    output logic [ID_W-1:0]   rid_o,
    output logic [BEAT_W-1:0] data_o,
    output logic [ECC_W-1:0]  ecc_o
);
    localparam int DMAX  = (RESP_DELAY > GAP_CYC) ? RESP_DELAY : GAP_CYC;
    localparam int DLY_W = $clog2(DMAX + 2);
    localparam logic YIELD = INSTANCE[0];

    typedef struct packed {
        seq_st_e           st;
        logic [DLY_W-1:0]  cnt;
        logic              grp;
        logic              own;
        logic [LINE_W-1:0] line;
        logic              vld;
        logic [1:0]        qid;
        logic [ID_W-1:0]   rid;
        logic [BEAT_W-1:0] data;
        logic [ECC_W-1:0]  ecc;
    } seq_t;

    seq_t d, q;
    logic hzd, gnt;
    logic [1:0] base, bq;
    logic [7:0][63:0] words;

    always_comb begin
        d     = q;
        pop_o = 1'b0;
        hzd   = wr_busy_i && (wr_line_addr_i[LA_W-1:3] == head_hi_i[HI_W-1:2]);
        gnt   = !peer_own_i && !(peer_req_i && YIELD);
        unique case (q.st)
            S_IDLE: if (head_vld_i) begin d.st = S_WAIT; d.cnt = '0; end
            S_WAIT: if (q.cnt == DLY_W'(RESP_DELAY)) d.st = S_ARB;
                    else d.cnt = q.cnt + 1'b1;
            S_ARB:  if (gnt && !hzd) begin
                        d.st   = S_V0;
                        d.own  = 1'b1;
                        d.grp  = 1'b0;
                        d.line = head_dummy_i ? '0 : line_i;
                    end
            S_V0:   d.st = S_V1;
            S_V1:   d.st = S_GAP;
            S_GAP:  d.st = S_D0;
            S_D0:   d.st = S_D1;
            S_D1:   if (q.grp) d.st = S_DONE;
                    else begin
                        d.grp = 1'b1;
                        d.cnt = '0;
                        d.st  = (GAP_CYC == 0) ? S_V0 : S_IGAP;
                    end
            S_IGAP: if (q.cnt == DLY_W'(GAP_CYC - 1)) d.st = S_V0;
                    else d.cnt = q.cnt + 1'b1;
            S_DONE: begin d.own = 1'b0; d.st = S_IDLE; pop_o = 1'b1; end
            default: d.st = S_IDLE;
        endcase
        // registered outputs follow the next state
        base   = {head_a5_i, 1'b0} + {d.grp, 1'b0};
        d.vld  = (d.st == S_V0) || (d.st == S_V1);
        d.qid  = d.vld ? ((d.st == S_V1) ? base + 2'd1 : base) : 2'd0;
        d.rid  = d.vld ? head_id_i : '0;
        bq     = (d.st == S_D1) ? base + 2'd1 : base;
        words  = q.line;
        d.data = FILLER;
        d.ecc  = '0;
        if ((d.st == S_D0) || (d.st == S_D1)) begin
            d.data = {words[{bq, 1'b0}], words[{bq, 1'b1}]};
            d.ecc  = beat_code(words[{bq, 1'b0}], words[{bq, 1'b1}]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.data <= FILLER;
        end else begin
            q <= d;
        end
    end

    assign pop_dummy_o = pop_o && head_dummy_i;
    assign bus_req_o   = (q.st == S_ARB);
    assign bus_own_o   = q.own;
    assign vld_o       = q.vld;
    assign qid_o       = q.qid;
    assign rid_o       = q.rid;
    assign data_o      = q.data;
    assign ecc_o       = q.ecc;

    // R5
    vld_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.vld) |-> $past(q.vld, 2));
    // R6
    qid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld && $past(q.vld)) |-> (q.qid == $past(q.qid) + 2'd1));
    // R9
    own_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> q.own);
    // R9
    no_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.own) |-> !$past(peer_own_i));
    // R11
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.own) |-> !$past(hzd));

endmodule

// File: rtl/line_return_seq.sv
`timescale 1ns/1ps
module line_return_seq
    import lrs_pkg::*;
#(
    parameter int INSTANCE   = 1,
    parameter int SLOTS      = 8,
    parameter int ID_W       = 3,
    parameter int ACK_DELAY  = 2,
    parameter int RESP_DELAY = 1,
    parameter int GAP_CYC    = 2,
    parameter int LINE_IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [32:0]       rd_addr_hi_i,
    input  logic              rd_addr5_i,
    input  logic [ID_W-1:0]   rd_id_i,
    input  logic              rd_dummy_i,
    output logic              rd_ack_o,
    input  logic              wr_en_i,
    input  logic              wr_busy_i,
    input  logic [33:0]       wr_line_addr_i,
    input  logic [511:0]      wr_line_i,
    input  logic              peer_own_i,
    input  logic              peer_req_i,
    output logic              bus_req_o,
    output logic              bus_own_o,
    output logic              rsp_vld_o,
    output logic [1:0]        rsp_qid_o,
    output logic [ID_W-1:0]   rsp_id_o,
    output logic [127:0]      rsp_data_o,
    output logic [27:0]       rsp_ecc_o
);
    localparam int ENT_W = HI_W + 1 + ID_W + 1;

    logic             push, pop, pop_dummy, head_vld;
    logic [ENT_W-1:0] head;
    logic [HI_W-1:0]  head_hi;
    logic             head_a5, head_dummy;
    logic [ID_W-1:0]  head_id;
    logic [LA_W-1:0]  head_line_addr;
    logic [LINE_W-1:0] rd_line;

    lrs_ack_ctrl #(.SLOTS(SLOTS), .ACK_DELAY(ACK_DELAY)) ack_i (
        .clk, .rst_n,
        .req_i(rd_req_i), .dummy_i(rd_dummy_i),
        .done_i(pop), .done_dummy_i(pop_dummy),
        .push_o(push), .ack_o(rd_ack_o)
    );

    lrs_req_fifo #(.DEPTH(SLOTS), .W(ENT_W)) fifo_i (
        .clk, .rst_n,
        .push_i(push), .din_i({rd_addr_hi_i, rd_addr5_i, rd_id_i, rd_dummy_i}),
        .pop_i(pop), .vld_o(head_vld), .dout_o(head)
    );

    assign {head_hi, head_a5, head_id, head_dummy} = head;
    assign head_line_addr = {head_hi, INSTANCE[0]};

    lrs_line_store #(.IDX_W(LINE_IDX_W)) store_i (
        .clk, .rst_n,
        .wr_en_i, .wr_idx_i(wr_line_addr_i[LINE_IDX_W-1:0]), .wr_line_i,
        .rd_idx_i(head_line_addr[LINE_IDX_W-1:0]), .rd_line_o(rd_line)
    );

    lrs_beat_seq #(.INSTANCE(INSTANCE), .ID_W(ID_W),
                   .RESP_DELAY(RESP_DELAY), .GAP_CYC(GAP_CYC)) seq_i (
        .clk, .rst_n,
        .head_vld_i(head_vld), .head_hi_i(head_hi), .head_a5_i(head_a5),
        .head_id_i(head_id), .head_dummy_i(head_dummy), .line_i(rd_line),
        .wr_busy_i, .wr_line_addr_i, .peer_own_i, .peer_req_i,
        .pop_o(pop), .pop_dummy_o(pop_dummy),
        .bus_req_o, .bus_own_o,
        .vld_o(rsp_vld_o), .qid_o(rsp_qid_o), .rid_o(rsp_id_o),
        .data_o(rsp_data_o), .ecc_o(rsp_ecc_o)
    );

endmodule

// File: tb/line_return_seq_tb.sv
`timescale 1ns/1ps
module line_return_seq_tb_top;
    localparam int ID_W = 3;
    localparam int ACK_DELAY = 2;
    localparam int GAP_CYC = 2;
    localparam int SLOTS = 8;
    localparam logic [127:0] FILL = {4{32'hDEAD_BEEF}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_req_i = 0, rd_addr5_i = 0, rd_dummy_i = 0;
    logic [32:0] rd_addr_hi_i = '0;
    logic [ID_W-1:0] rd_id_i = '0;
    logic rd_ack_o, wr_en_i = 0, wr_busy_i = 0, peer_own_i = 0, peer_req_i = 0;
    logic [33:0] wr_line_addr_i = '0;
    logic [511:0] wr_line_i = '0;
    logic bus_req_o, bus_own_o, rsp_vld_o;
    logic [1:0] rsp_qid_o;
    logic [ID_W-1:0] rsp_id_o;
    logic [127:0] rsp_data_o;
    logic [27:0] rsp_ecc_o;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [511:0] exp_mem [8];

    always #2.5 clk = ~clk;

    line_return_seq dut_i (.*);

    task automatic chk(input bit ok, input string tag,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] make_line(input int idx, input int gen);
        logic [511:0] l;
        for (int i = 0; i < 8; i++)
            l[64*i +: 64] = 64'h9E37_79B9_7F4A_7C15 * 64'(idx * 16 + gen * 8 + i + 1);
        return l;
    endfunction

    function automatic logic [6:0] code7(input logic [31:0] d);
        logic p, e1, e0;
        p = 0; e1 = 0; e0 = 0;
        for (int i = 0; i < 32; i++) begin
            if (32'h2DA6_5CB7 & (32'h1 << i)) p  ^= d[i];
            if (32'h9B33_366D & (32'h1 << i)) e1 ^= d[i];
            if (32'h56AA_AD5B & (32'h1 << i)) e0 ^= d[i];
        end
        return {p, ^d[31:26], ^d[25:11], (^d[25:18]) ^ (^d[10:4]),
                (^d[31:29]) ^ (^d[25:22]) ^ (^d[17:14]) ^ (^d[10:7]) ^ (^d[3:1]),
                e1, e0};
    endfunction

    task automatic wr_line(input logic [33:0] la, input logic [511:0] l);
        @(negedge clk);
        wr_en_i = 1; wr_line_addr_i = la; wr_line_i = l;
        @(negedge clk);
        wr_en_i = 0;
        exp_mem[la[2:0]] = l;
    endtask

    task automatic send_req(input logic [32:0] hi, input logic a5, input logic [ID_W-1:0] id,
                            input logic dm, input int max_wait,
                            output int edges, output bit acked);
        @(negedge clk);
        rd_req_i = 1; rd_addr_hi_i = hi; rd_addr5_i = a5; rd_id_i = id; rd_dummy_i = dm;
        edges = 0; acked = 0;
        while (!acked && edges < max_wait) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (rd_ack_o) acked = 1;
        end
        if (acked) begin
            rd_req_i = 0;
            @(negedge clk);
            chk(!rd_ack_o, "R1 ack one cycle", rd_ack_o, 0);
        end
    endtask

    task automatic collect(input logic [ID_W-1:0] id, input logic [511:0] line, input logic a5);
        int w;
        int q;
        logic [63:0] w0, w1;
        w = 0;
        while (!rsp_vld_o && w < 300) begin @(negedge clk); w++; end
        chk(rsp_vld_o, "R13 return appears", rsp_vld_o, 1);
        for (int g = 0; g < 2; g++) begin
            for (int k = 0; k < 2; k++) begin
                q = (2 * int'(a5) + 2 * g + k) % 4;
                chk(rsp_vld_o, "R5 strobe high", rsp_vld_o, 1);
                chk(rsp_qid_o == 2'(q), "R6 R4 qword id", rsp_qid_o, q);
                chk(rsp_id_o == id, "R13 R5 tag", rsp_id_o, id);
                chk(bus_own_o, "R9 own during strobe", bus_own_o, 1);
                @(negedge clk);
            end
            chk(!rsp_vld_o, "R5 quiet cycle", rsp_vld_o, 0);
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                q = (2 * int'(a5) + 2 * g + k) % 4;
                w0 = line[64*(2*q) +: 64];
                w1 = line[64*(2*q+1) +: 64];
                chk(rsp_data_o == {w0, w1}, "R7 R4 R6 beat data", rsp_data_o, {w0, w1});
                chk(rsp_ecc_o == {code7(w0[63:32]), code7(w0[31:0]), code7(w1[63:32]), code7(w1[31:0])},
                    "R8 beat code", rsp_ecc_o,
                    {code7(w0[63:32]), code7(w0[31:0]), code7(w1[63:32]), code7(w1[31:0])});
                chk(bus_own_o, "R9 own during beat", bus_own_o, 1);
                @(negedge clk);
            end
            if (g == 0)
                for (int c = 0; c < GAP_CYC; c++) begin
                    chk(!rsp_vld_o, "R6 group gap", rsp_vld_o, 0);
                    chk(rsp_data_o == FILL, "R12 filler in gap", rsp_data_o, FILL);
                    @(negedge clk);
                end
        end
        chk(rsp_data_o == FILL && rsp_ecc_o == 0, "R12 filler after", rsp_data_o, FILL);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL R13 watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e;
        bit a;
        logic [511:0] nl;
        for (int i = 0; i < 8; i++) exp_mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(!rd_ack_o && !rsp_vld_o && !bus_req_o && !bus_own_o, "R12 reset quiet",
            {rd_ack_o, rsp_vld_o, bus_req_o, bus_own_o}, 0);
        chk(rsp_data_o == FILL && rsp_ecc_o == 0, "R12 reset filler", rsp_data_o, FILL);

        // sweep: stored lines x start quadword x index
        for (int gen = 0; gen < 2; gen++) begin
            for (int j = 0; j < 8; j++) wr_line({31'(gen + 1), 3'(j)}, make_line(j, gen));
            for (int h = 0; h < 4; h++)
                for (int a5 = 0; a5 < 2; a5++) begin
                    send_req({31'(gen + 1), 2'(h)}, 1'(a5), 3'(h * 2 + a5 + gen), 0, 20, e, a);
                    chk(a && e == ACK_DELAY + 1, "R1 ack delay", e, ACK_DELAY + 1);
                    collect(3'(h * 2 + a5 + gen), exp_mem[{2'(h), 1'b1}], 1'(a5));
                end
        end

        // R10 dummy read
        send_req({31'h9, 2'd1}, 1, 3'd5, 1, 20, e, a);
        chk(a, "R10 dummy acked", a, 1);
        collect(3'd5, '0, 1);

        // R9 yield to waiting peer
        peer_req_i = 1;
        send_req({31'h1, 2'd2}, 0, 3'd6, 0, 20, e, a);
        repeat (15) @(negedge clk);
        chk(bus_req_o && !bus_own_o && !rsp_vld_o, "R9 yield", {bus_req_o, bus_own_o, rsp_vld_o}, 3'b100);
        peer_req_i = 0;
        collect(3'd6, exp_mem[5], 0);

        // R11 write hazard on block
        wr_busy_i = 1; wr_line_addr_i = {31'h5, 3'b011};
        send_req({31'h5, 2'b01}, 0, 3'd2, 0, 20, e, a);
        repeat (20) @(negedge clk);
        chk(!rsp_vld_o && !bus_own_o, "R11 stall", rsp_vld_o, 0);
        nl = make_line(3, 7);
        wr_en_i = 1; wr_line_i = nl;
        @(negedge clk);
        wr_en_i = 0; wr_busy_i = 0; exp_mem[3] = nl;
        collect(3'd2, nl, 0);

        // R2 outstanding limit and R13 order
        peer_own_i = 1;
        for (int k = 0; k < SLOTS; k++) begin
            send_req({31'(k + 2), 2'(k % 4)}, 1'(k % 2), 3'(k), 0, 20, e, a);
            chk(a, "R2 accepted below limit", a, 1);
        end
        send_req({31'h20, 2'd0}, 0, 3'd7, 0, 30, e, a);
        chk(!a, "R2 withheld when full", a, 0);
        peer_own_i = 0;
        collect(3'd0, exp_mem[1], 0);
        a = 0;
        for (int c = 0; c < 10 && !a; c++) begin
            @(posedge clk); @(negedge clk);
            if (rd_ack_o) a = 1;
        end
        rd_req_i = 0;
        chk(a, "R2 acked after slot frees", a, 1);
        for (int k = 1; k < SLOTS; k++)
            collect(3'(k), exp_mem[{2'(k % 4), 1'b1}], 1'(k % 2));
        collect(3'd7, exp_mem[1], 0);

        // R3 single dummy
        peer_own_i = 1;
        send_req({31'h3, 2'd0}, 0, 3'd1, 1, 20, e, a);
        chk(a, "R3 first dummy acked", a, 1);
        send_req({31'h3, 2'd1}, 0, 3'd2, 1, 20, e, a);
        chk(!a, "R3 second dummy withheld", a, 0);
        rd_req_i = 0;
        send_req({31'h3, 2'd2}, 1, 3'd3, 0, 20, e, a);
        chk(a, "R3 normal accepted", a, 1);
        peer_own_i = 0;
        collect(3'd1, '0, 0);
        collect(3'd3, exp_mem[5], 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule